// File: doc/BRIEF.md
# Checkpointed Register Alias Table

This block holds the live mapping from each architectural register to the physical register that currently holds its value. It also keeps a small ring of whole-table snapshots. Rename logic writes new mappings through several write ports each cycle. Write port order is program order inside a rename group. Several read ports return current mappings one cycle after the address is presented.

When a rename group contains an instruction that starts speculation, such as a predicted branch, the renamer requests a checkpoint and gives the position of that instruction within the group. The block copies the full table into a free slot and returns the slot number. That copy includes the writes from the group's ports up to and including that position. It excludes writes from ports after it. The slot stays held until the renamer releases it by number when the instruction commits.

On a misprediction, a restore by number copies the selected snapshot back over the live table in one cycle, no matter how much work is undone. The same restore drops every checkpoint taken after the restored one.

Top module: `ckpt_rat`

## Requirements
- R1: After a synchronous active-high reset, every entry i of the live table holds physical name i. No checkpoint is held, `ckpt_full` is 0 and `ckpt_next_id` is 0.
- R2: Each read port returns, one cycle after its address is presented, the entry value from before any write or restore in that same cycle.
- R3: An enabled write updates its entry for reads from the next cycle on. When several ports write the same entry in one cycle, the highest-numbered port wins. With no write and no restore, the table does not change.
- R4: An allocate request accepted while `ckpt_full` is 0 takes the slot shown on `ckpt_next_id`. Slots are handed out in ring order 0, 1, …, NUM_CKPT-1, 0, ….
- R5: The snapshot stored by an allocate equals the table after applying only the writes on ports 0 to `alloc_pos` of that cycle. Writes on higher ports reach the live table but not the snapshot.
- R6: `ckpt_full` is 1 exactly when the slot at `ckpt_next_id` is still held. `alloc_stall` equals `alloc_req` AND `ckpt_full`. A stalled request stores nothing and does not move `ckpt_next_id`.
- R7: A release frees the named slot. Once the slot at `ckpt_next_id` is freed, `ckpt_full` returns to 0.
- R8: A restore makes the live table equal to the named snapshot in the next cycle, with a fixed latency of one cycle.
- R9: A restore frees every checkpoint allocated after the named one and keeps the named one held. `ckpt_next_id` becomes the named slot plus one, modulo NUM_CKPT.
- R10: In a restore cycle, writes and allocate requests of that cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | NUM_RD*AW | Packed architectural read addresses, port r at bits r*AW |
| rd_data | output | NUM_RD*PW | Packed registered read results |
| wr_en | input | NUM_WR | Per-port write enable, bit p for port p |
| wr_arch | input | NUM_WR*AW | Packed architectural write targets |
| wr_phys | input | NUM_WR*PW | Packed new physical names |
| alloc_req | input | 1 | Take a checkpoint this cycle |
| alloc_pos | input | WPW | Last write port included in the snapshot |
| alloc_stall | output | 1 | Allocate refused because the ring is full |
| ckpt_next_id | output | CW | Slot number the next accepted allocate gets |
| ckpt_full | output | 1 | Next slot is still held |
| rel_en | input | 1 | Release a checkpoint |
| rel_id | input | CW | Slot to release |
| restore_en | input | 1 | Restore the live table from a snapshot |
| restore_id | input | CW | Slot to restore from |

## Verification
The assertions check on every cycle that:
- a restore copies the selected snapshot into the live table and moves the allocation pointer to the slot after it;
- an accepted allocate marks its slot held;
- a stalled allocate leaves the pointer alone;
- the table holds still when nothing writes it.

Only the bench scenarios can show:
- the contents of snapshots taken with a given write-port cut and read back much later;
- highest-port-wins merging;
- read-before-write timing;
- which older and younger slots survive a restore in a wrapped, full ring.

// File: rtl/ckrat_pkg.sv
package ckrat_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // forward distance around a ring of 'slots' entries
  function automatic int ring_gap(input int from_slot, input int to_slot, input int slots);
    return (to_slot - from_slot + slots) % slots;
  endfunction

  function automatic int ring_next(input int slot, input int slots);
    return (slot + 1) % slots;
  endfunction
endpackage

// File: rtl/ckrat_merge.sv
module ckrat_merge #(
  parameter int ARCH = 64,
  parameter int PW   = 7,
  parameter int AW   = 6,
  parameter int NW   = 4,
  parameter int WPW  = 2
) (
  input  logic [ARCH*PW-1:0] base,
  input  logic [NW-1:0]      wr_en,
  input  logic [NW*AW-1:0]   wr_arch,
  input  logic [NW*PW-1:0]   wr_phys,
  input  logic [WPW-1:0]     last_port,
  output logic [ARCH*PW-1:0] merged
);
  timeunit 1ns;
  timeprecision 1ps;

  // later ports overwrite earlier ones: program order inside the group
  always_comb begin
    merged = base;
    for (int p = 0; p < NW; p++) begin
      if (wr_en[p] && (p <= int'(last_port))) begin
        merged[int'(wr_arch[p*AW +: AW])*PW +: PW] = wr_phys[p*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/ckrat_snap_store.sv
module ckrat_snap_store #(
  parameter int SLOTS = 16,
  parameter int CW    = 4,
  parameter int TW    = 448
) (
  input  logic          clk,
  input  logic          we,
  input  logic [CW-1:0] waddr,
  input  logic [TW-1:0] wdata,
  input  logic [CW-1:0] raddr,
  output logic [TW-1:0] rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [TW-1:0] mem_q [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  // asynchronous read keeps restore at one cycle
  assign rdata = mem_q[raddr];
endmodule

// File: rtl/ckrat_ckpt_ctrl.sv
module ckrat_ckpt_ctrl
  import ckrat_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_req,
  input  logic          rel_en,
  input  logic [CW-1:0] rel_id,
  input  logic          restore_en,
  input  logic [CW-1:0] restore_id,
  output logic          alloc_fire,
  output logic          alloc_stall,
  output logic          full,
  output logic [CW-1:0] next_id
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [SLOTS-1:0] valid_q, valid_d, younger;
  logic [CW-1:0]    tail_q, tail_d;

  assign full        = valid_q[tail_q];
  assign alloc_stall = alloc_req & full;
  assign alloc_fire  = alloc_req & ~full & ~restore_en;
  assign next_id     = tail_q;

  // slots strictly between the restored one and the allocation pointer
  always_comb begin
    int span;
    span = ring_gap(int'(restore_id), int'(tail_q), SLOTS);
    if (span == 0) span = SLOTS;
    for (int i = 0; i < SLOTS; i++) begin
      younger[i] = (ring_gap(int'(restore_id), i, SLOTS) > 0) &&
                   (ring_gap(int'(restore_id), i, SLOTS) < span);
    end
  end

  always_comb begin
    valid_d = valid_q;
    tail_d  = tail_q;
    if (rel_en) valid_d[rel_id] = 1'b0;
    if (restore_en) begin
      valid_d = valid_d & ~younger;
      tail_d  = CW'(ring_next(int'(restore_id), SLOTS));
    end else if (alloc_fire) begin
      valid_d[tail_q] = 1'b1;
      tail_d          = CW'(ring_next(int'(tail_q), SLOTS));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      tail_q  <= '0;
    end else begin
      valid_q <= valid_d;
      tail_q  <= tail_d;
    end
  end

  // R4
  alloc_sets_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |=> valid_q[$past(tail_q)]);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_stall && !restore_en) |=> tail_q == $past(tail_q));

  // R9
  restore_tail_chk: assert property (@(posedge clk) disable iff (rst)
    restore_en |=> int'(tail_q) == ring_next(int'($past(restore_id)), SLOTS));

  // R9
  restore_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (restore_en && !(rel_en && rel_id == restore_id))
      |=> valid_q[$past(restore_id)] == $past(valid_q[restore_id]));
endmodule

// File: rtl/ckpt_rat.sv
module ckpt_rat #(
  parameter int ARCH_REGS = 64,
  parameter int PHYS_REGS = 128,
  parameter int NUM_CKPT  = 16,
  parameter int NUM_RD    = 8,
  parameter int NUM_WR    = 4,
  localparam int AW  = $clog2(ARCH_REGS),
  localparam int PW  = $clog2(PHYS_REGS),
  localparam int CW  = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
  localparam int WPW = (NUM_WR > 1) ? $clog2(NUM_WR) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RD*AW-1:0] rd_addr,
  output logic [NUM_RD*PW-1:0] rd_data,
  input  logic [NUM_WR-1:0]    wr_en,
  input  logic [NUM_WR*AW-1:0] wr_arch,
  input  logic [NUM_WR*PW-1:0] wr_phys,
  input  logic                 alloc_req,
  input  logic [WPW-1:0]       alloc_pos,
  output logic                 alloc_stall,
  output logic [CW-1:0]        ckpt_next_id,
  output logic                 ckpt_full,
  input  logic                 rel_en,
  input  logic [CW-1:0]        rel_id,
  input  logic                 restore_en,
  input  logic [CW-1:0]        restore_id
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TW = ARCH_REGS * PW;

  logic [TW-1:0] live_q, group_tbl, prefix_tbl, snap_rdata;
  logic          alloc_fire;

  ckrat_merge #(.ARCH(ARCH_REGS), .PW(PW), .AW(AW), .NW(NUM_WR), .WPW(WPW)) u_group (
    .base(live_q), .wr_en(wr_en), .wr_arch(wr_arch), .wr_phys(wr_phys),
    .last_port(WPW'(NUM_WR - 1)), .merged(group_tbl));

  ckrat_merge #(.ARCH(ARCH_REGS), .PW(PW), .AW(AW), .NW(NUM_WR), .WPW(WPW)) u_prefix (
    .base(live_q), .wr_en(wr_en), .wr_arch(wr_arch), .wr_phys(wr_phys),
    .last_port(alloc_pos), .merged(prefix_tbl));

  ckrat_ckpt_ctrl #(.SLOTS(NUM_CKPT), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .rel_en(rel_en), .rel_id(rel_id),
    .restore_en(restore_en), .restore_id(restore_id), .alloc_fire(alloc_fire),
    .alloc_stall(alloc_stall), .full(ckpt_full), .next_id(ckpt_next_id));

  ckrat_snap_store #(.SLOTS(NUM_CKPT), .CW(CW), .TW(TW)) u_store (
    .clk(clk), .we(alloc_fire), .waddr(ckpt_next_id), .wdata(prefix_tbl),
    .raddr(restore_id), .rdata(snap_rdata));

  // live table: restore overrides the group's writes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) live_q[i*PW +: PW] <= PW'(i);
    end else if (restore_en) begin
      live_q <= snap_rdata;
    end else begin
      live_q <= group_tbl;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    logic [PW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= live_q[int'(rd_addr[r*AW +: AW])*PW +: PW];
    end
    assign rd_data[r*PW +: PW] = q;
  end

  // R8 R10
  restore_copy_chk: assert property (@(posedge clk) disable iff (rst)
    restore_en |=> live_q == $past(snap_rdata));

  // R3
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!restore_en && wr_en == '0) |=> $stable(live_q));
endmodule

// File: tb/ckpt_rat_test.sv
module ckpt_rat_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NA = 8, NP = 16, NC = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] wr_en = '0;
  logic [5:0] wr_arch = '0;
  logic [7:0] wr_phys = '0;
  logic alloc_req = 1'b0, alloc_stall, ckpt_full, rel_en = 1'b0, restore_en = 1'b0;
  logic [0:0] alloc_pos = '0;
  logic [1:0] ckpt_next_id, rel_id = '0, restore_id = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  int m[NA];
  int ck[NC][NA];
  bit v[NC];
  int tl;

  ckpt_rat #(.ARCH_REGS(NA), .PHYS_REGS(NP), .NUM_CKPT(NC), .NUM_RD(2), .NUM_WR(2)) uut (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_arch(wr_arch), .wr_phys(wr_phys), .alloc_req(alloc_req), .alloc_pos(alloc_pos),
    .alloc_stall(alloc_stall), .ckpt_next_id(ckpt_next_id), .ckpt_full(ckpt_full),
    .rel_en(rel_en), .rel_id(rel_id), .restore_en(restore_en), .restore_id(restore_id));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_table(input string req);
    for (int k = 0; k < NA / 2; k++) begin
      rd_addr = {3'(2 * k + 1), 3'(2 * k)};
      @(negedge clk);
      chk(int'(rd_data[3:0]) == m[2 * k], req, int'(rd_data[3:0]), m[2 * k]);
      chk(int'(rd_data[7:4]) == m[2 * k + 1], req, int'(rd_data[7:4]), m[2 * k + 1]);
    end
  endtask

  task automatic check_status(input string req);
    chk(int'(ckpt_next_id) == tl, req, int'(ckpt_next_id), tl);
    chk(ckpt_full == v[tl], req, int'(ckpt_full), int'(v[tl]));
  endtask

  task automatic step(input bit e0, input int a0, input int p0, input bit e1, input int a1,
                      input int p1, input bit al, input int pos, input bit rl, input int rid,
                      input bit rs, input int sid);
    int pre[NA];
    int nxt[NA];
    bit full_b;
    int span;
    wr_en = {e1, e0};
    wr_arch = {3'(a1), 3'(a0)};
    wr_phys = {4'(p1), 4'(p0)};
    alloc_req = al; alloc_pos = 1'(pos);
    rel_en = rl; rel_id = 2'(rid);
    restore_en = rs; restore_id = 2'(sid);
    #1;
    full_b = v[tl];
    if (al) begin
      chk(alloc_stall == full_b, "R6 stall", int'(alloc_stall), int'(full_b));
      if (!full_b) chk(int'(ckpt_next_id) == tl, "R4 id", int'(ckpt_next_id), tl);
    end
    @(posedge clk);
    nxt = m; pre = m;
    if (e0) begin nxt[a0] = p0; pre[a0] = p0; end
    if (e1) begin nxt[a1] = p1; if (pos >= 1) pre[a1] = p1; end
    if (rl) v[rid] = 1'b0;
    if (rs) begin
      span = (tl - sid + NC) % NC;
      if (span == 0) span = NC;
      for (int i = 0; i < NC; i++)
        if ((i - sid + NC) % NC > 0 && (i - sid + NC) % NC < span) v[i] = 1'b0;
      m = ck[sid];
      tl = (sid + 1) % NC;
    end else begin
      m = nxt;
      if (al && !full_b) begin
        ck[tl] = pre; v[tl] = 1'b1; tl = (tl + 1) % NC;
      end
    end
    @(negedge clk);
    wr_en = '0; alloc_req = 1'b0; rel_en = 1'b0; restore_en = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t, old;
    for (int i = 0; i < NA; i++) m[i] = i;
    for (int i = 0; i < NC; i++) v[i] = 1'b0;
    tl = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_status("R1");
    check_table("R1");

    // R3 single writes over every entry, then same-entry conflicts
    for (int e = 0; e < NA; e++) step(1, e, (e * 3 + 5) % NP, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check_table("R3");
    step(1, 2, 9, 1, 2, 11, 0, 0, 0, 0, 0, 0);
    step(1, 5, 4, 1, 6, 7, 0, 0, 0, 0, 0, 0);
    check_table("R3");

    // R2 read sees value before same-cycle write
    old = m[2];
    rd_addr = {3'd0, 3'd2};
    step(1, 2, 13, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(int'(rd_data[3:0]) == old, "R2 old", int'(rd_data[3:0]), old);
    @(negedge clk);
    chk(int'(rd_data[3:0]) == 13, "R2 new", int'(rd_data[3:0]), 13);

    // R5 R8 sweep of write-port cut and enable pattern
    for (int pos = 0; pos < 2; pos++) begin
      for (int en = 0; en < 4; en++) begin
        int id;
        id = tl;
        step(en[0], en, (pos * 4 + en + 1) % NP, en[1], 7 - en, (pos * 4 + en + 9) % NP,
             1, pos, 0, 0, 0, 0);
        step(1, en, 15, 1, 7 - en, 14, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, id);
        check_table("R5 R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, id, 0, 0);
      end
    end

    // R4 R6 fill the ring
    t = tl;
    for (int k = 0; k < NC; k++) step(1, k, 10 + k, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    check_status("R6 full");
    step(1, 7, 3, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    check_status("R6 held");
    // R7 release oldest
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, t, 0, 0);
    check_status("R7");
    step(1, 6, 2, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    check_status("R4 wrap");
    // R10 R9 restore mid-ring with competing writes and allocate
    step(1, 0, 3, 1, 1, 3, 1, 0, 0, 0, 1, (t + 2) % NC);
    check_table("R10");
    check_status("R9 freed");
    step(1, 4, 8, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(1, 5, 9, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    check_status("R9 kept");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, (t + 2) % NC);
    check_table("R9 R8");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule